// File: doc/BRIEF.md
# On-Screen Character Overlay Generator

This block draws a text overlay onto a video raster. It stores a grid of 8 character rows by 20 character columns and one color per row. It follows the horizontal and vertical sync inputs, counting pixel clocks and lines. For every pixel clock it reports whether a glyph dot is lit and, if so, which 3-bit color code it carries. A downstream mixer uses these two outputs to key the overlay over the picture.

Glyphs come from a computed font. The dot cell is either a coarse 5x7 pattern or a fine 11x15 pattern, and a control bit picks between them. One row can be chosen as a bar row. Cells of that row from a programmable column onward take a second color, so a volume or level indicator can be drawn as a row of solid characters.

Settings arrive through a byte-wide write port and land in a shadow copy. That copy is transferred to the working copy only when the frame restarts, so a half-written update is never seen on screen. The vertical position inside the frame is tracked by a four-state machine:
- `V_WAIT`: the state after reset; nothing is shown until the first vertical sync edge.
- `V_ABOVE`: lines above the grid.
- `V_ROWS`: lines inside the grid.
- `V_BELOW`: lines below the grid.

The transitions are:
- A vertical sync falling edge moves any state to `V_ABOVE`, or directly to `V_ROWS` when the vertical start position is 0.
- `V_ABOVE` moves to `V_ROWS` when the line count reaches the vertical start position.
- `V_ROWS` moves to `V_BELOW` when the line count reaches the vertical start position plus the grid height.

Top module: `osd_overlay`

## Requirements
- R1: Character cells are written at address `row*20 + col` (addresses 0 to 159). The code is taken from `wr_data[6:0]`, giving 128 possible glyphs.
- R2: Row colors are at addresses 160+row, in `wr_data[2:0]`. The remaining settings are at these addresses:
  - 168: bar row index, `[2:0]`.
  - 169: second bar color, `[2:0]`.
  - 170: split column, `[4:0]`.
  - 171: horizontal start in pixel clocks, `[7:0]`.
  - 172: vertical start in lines, `[7:0]`.
  - 173: control. Bit 0 enables the display; bit 1 selects the 11x15 mode (0 selects 5x7).
- R3: A write changes only the shadow settings. The shadow settings are copied into use at the clock that samples a falling edge on `vsync`. Until then every pixel is drawn with the previous settings.
- R4: Pixel index k is the number of clocks since the clock that sampled `hsync` fall. Line index L is the number of `hsync` falling edges since the `vsync` falling edge. The outputs for pixel k are valid after the clock that follows the one that made the pixel index k.
- R5: The grid window spans horizontally from pixel hstart to hstart + 20·cellw − 1, and vertically from line vstart to vstart + 8·cellh − 1. No dot is lit outside the window.
- R6: The cell is 6x8 in 5x7 mode and 12x16 in 11x15 mode. Dots in the last cell column and the last cell line are always blank.
- R7: Inside the glyph area, with gx and gy the dot coordinates inside the cell, a dot is lit when bit `(gx+gy) mod 7` of the code is 1. Code 0 never lights a dot.
- R8: A lit dot takes its row's color. When `pix_on` is 0, `pix_color` is 0.
- R9: In the bar row, cells whose column is greater than or equal to the split column use the second bar color. A split of 20 or more leaves the row in a single color.
- R10: With the enable bit clear, `pix_on` stays 0.
- R11: After reset, all settings are 0 and both outputs are 0. No dot is lit before the first `vsync` falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, falling edge starts a line |
| vsync | input | 1 | Vertical sync, falling edge starts a frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pix_on | output | 1 | Overlay dot lit for this pixel |
| pix_color | output | 3 | Color code of the lit dot, 0 otherwise |

## Verification
Some properties are checked by assertions on every cycle:
- The working settings hold still except at a frame start.
- The line machine never stays in its post-reset wait once a frame has begun.
- The grid state is never entered above the vertical start line.
- A lit dot is never produced while the display is disabled.

Other behaviour can only be shown by the bench's frames. Each one is compared pixel by pixel against a model:
- glyph shapes and cell spacing in both resolutions;
- window placement at zero and non-zero offsets;
- row colors and the bar split at column 0, mid-row and beyond the last column;
- a shadow write made in mid-frame staying invisible until the next vertical sync.

// File: rtl/osd_pkg.sv
package osd_pkg;
    localparam int ROWS    = 8;
    localparam int COLS    = 20;
    localparam int NCELL   = ROWS * COLS;
    localparam int CODE_W  = 7;
    localparam int COLOR_W = 3;
    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = 5;
    localparam int CELL_W  = $clog2(NCELL);
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int POS_W   = 8;
    localparam int HCNT_W  = 10;
    localparam int VCNT_W  = 9;
    localparam int GXY_W   = 4;
    localparam int NMODES  = 2;

    localparam int A_RCOL   = NCELL;
    localparam int A_BARROW = NCELL + ROWS;
    localparam int A_BARCOL = A_BARROW + 1;
    localparam int A_SPLIT  = A_BARROW + 2;
    localparam int A_HPOS   = A_BARROW + 3;
    localparam int A_VPOS   = A_BARROW + 4;
    localparam int A_CTRL   = A_BARROW + 5;

    function automatic int cell_w(int m);
        return (m != 0) ? 12 : 6;
    endfunction
    function automatic int cell_h(int m);
        return (m != 0) ? 16 : 8;
    endfunction
    function automatic int glyph_w(int m);
        return cell_w(m) - 1;
    endfunction
    function automatic int glyph_h(int m);
        return cell_h(m) - 1;
    endfunction

    typedef enum logic [1:0] {V_WAIT, V_ABOVE, V_ROWS, V_BELOW} vstate_t;

    typedef struct packed {
        logic [NCELL-1:0][CODE_W-1:0] chr;
        logic [ROWS-1:0][COLOR_W-1:0] rcol;
        logic [ROW_W-1:0]             bar_row;
        logic [COLOR_W-1:0]           bar_col2;
        logic [COL_W-1:0]             split;
        logic [POS_W-1:0]             hstart;
        logic [POS_W-1:0]             vstart;
        logic                         en;
        logic                         hires;
    } osd_cfg_t;
endpackage

// File: rtl/osd_regs.sv
module osd_regs
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    output osd_cfg_t          active,
    output logic [POS_W-1:0]  nxt_vstart,
    output logic              nxt_hires
);
    osd_cfg_t shadow;
    logic [ROW_W-1:0] rsel;

    assign rsel = ROW_W'(wr_addr - ADDR_W'(A_RCOL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            if (wr_addr < ADDR_W'(A_RCOL))
                shadow.chr[CELL_W'(wr_addr)] <= wr_data[CODE_W-1:0];
            else if (wr_addr < ADDR_W'(A_BARROW))
                shadow.rcol[rsel] <= wr_data[COLOR_W-1:0];
            else if (wr_addr == ADDR_W'(A_BARROW))
                shadow.bar_row <= wr_data[ROW_W-1:0];
            else if (wr_addr == ADDR_W'(A_BARCOL))
                shadow.bar_col2 <= wr_data[COLOR_W-1:0];
            else if (wr_addr == ADDR_W'(A_SPLIT))
                shadow.split <= wr_data[COL_W-1:0];
            else if (wr_addr == ADDR_W'(A_HPOS))
                shadow.hstart <= wr_data;
            else if (wr_addr == ADDR_W'(A_VPOS))
                shadow.vstart <= wr_data;
            else if (wr_addr == ADDR_W'(A_CTRL)) begin
                shadow.en    <= wr_data[0];
                shadow.hires <= wr_data[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            active <= '0;
        else if (commit)
            active <= shadow;
    end

    assign nxt_vstart = commit ? shadow.vstart : active.vstart;
    assign nxt_hires  = commit ? shadow.hires  : active.hires;

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active));
endmodule

// File: rtl/osd_timing.sv
module osd_timing
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [POS_W-1:0]  nxt_vstart,
    input  logic              nxt_hires,
    input  logic [POS_W-1:0]  cur_vstart,
    output logic              frame_start,
    output logic [HCNT_W-1:0] hcnt,
    output logic [VCNT_W-1:0] vcnt,
    output logic              in_rows
);
    logic hs_q, vs_q, hfall;
    logic [VCNT_W-1:0] vcnt_d, vend;
    vstate_t state, state_d;

    assign hfall       = hs_q & ~hsync;
    assign frame_start = vs_q & ~vsync;
    assign vend = VCNT_W'(nxt_vstart) +
                  (nxt_hires ? VCNT_W'(ROWS * cell_h(1)) : VCNT_W'(ROWS * cell_h(0)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
            vcnt <= vcnt_d;
            if (hfall)
                hcnt <= '0;
            else if (hcnt != '1)
                hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        if (frame_start)
            vcnt_d = '0;
        else if (hfall && vcnt != '1)
            vcnt_d = vcnt + 1'b1;
        else
            vcnt_d = vcnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= V_WAIT;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        if (frame_start) begin
            state_d = (nxt_vstart == '0) ? V_ROWS : V_ABOVE;
        end else begin
            unique case (state)
                V_WAIT:  state_d = V_WAIT;
                V_ABOVE: if (vcnt_d == VCNT_W'(nxt_vstart)) state_d = V_ROWS;
                V_ROWS:  if (vcnt_d == vend) state_d = V_BELOW;
                V_BELOW: state_d = V_BELOW;
            endcase
        end
    end

    assign in_rows = (state == V_ROWS);

    // R11
    leave_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> state != V_WAIT);

    // R5
    rows_below_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rows |-> vcnt >= VCNT_W'(cur_vstart));
endmodule

// File: rtl/osd_render.sv
module osd_render
    import osd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  osd_cfg_t           cfg,
    input  logic [HCNT_W-1:0]  hcnt,
    input  logic [VCNT_W-1:0]  vcnt,
    input  logic               in_rows,
    output logic               pix_on,
    output logic [COLOR_W-1:0] pix_color
);
    logic [HCNT_W:0]   xo;
    logic [VCNT_W-1:0] yo;
    logic [COL_W-1:0]  col_m  [NMODES];
    logic [GXY_W-1:0]  gx_m   [NMODES];
    logic [ROW_W-1:0]  row_m  [NMODES];
    logic [GXY_W-1:0]  gy_m   [NMODES];
    logic              inx_m  [NMODES];
    logic              glyph_m[NMODES];

    assign xo = {1'b0, hcnt} - (HCNT_W+1)'(cfg.hstart);
    assign yo = vcnt - VCNT_W'(cfg.vstart);

    for (genvar m = 0; m < NMODES; m++) begin : g_geom
        localparam logic [HCNT_W:0]   CWX  = (HCNT_W+1)'(cell_w(m));
        localparam logic [HCNT_W:0]   SPAN = (HCNT_W+1)'(COLS * cell_w(m));
        localparam logic [VCNT_W-1:0] CHY  = VCNT_W'(cell_h(m));
        assign col_m[m]   = COL_W'(xo / CWX);
        assign gx_m[m]    = GXY_W'(xo % CWX);
        assign row_m[m]   = ROW_W'(yo / CHY);
        assign gy_m[m]    = GXY_W'(yo % CHY);
        assign inx_m[m]   = !xo[HCNT_W] && (xo < SPAN);
        assign glyph_m[m] = (gx_m[m] < GXY_W'(glyph_w(m))) &&
                            (gy_m[m] < GXY_W'(glyph_h(m)));
    end

    logic [COL_W-1:0]   col;
    logic [ROW_W-1:0]   row;
    logic [GXY_W-1:0]   gx, gy;
    logic               inx, in_glyph, dot;
    logic [CELL_W-1:0]  idx;
    logic [CODE_W-1:0]  code;
    logic [GXY_W:0]     gsum;
    logic [2:0]         bsel;
    logic [COLOR_W-1:0] color;

    always_comb begin
        col      = col_m[cfg.hires];
        row      = row_m[cfg.hires];
        gx       = gx_m[cfg.hires];
        gy       = gy_m[cfg.hires];
        inx      = inx_m[cfg.hires];
        in_glyph = glyph_m[cfg.hires];
        idx      = CELL_W'(row) * CELL_W'(COLS) + CELL_W'(col);
        code     = inx ? cfg.chr[idx] : '0;
        gsum     = (GXY_W+1)'(gx) + (GXY_W+1)'(gy);
        bsel     = 3'(gsum % (GXY_W+1)'(CODE_W));
        dot      = cfg.en && in_rows && inx && in_glyph &&
                   (code != '0) && code[bsel];
        if (row == cfg.bar_row && col >= cfg.split)
            color = cfg.bar_col2;
        else
            color = cfg.rcol[row];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_on    <= 1'b0;
            pix_color <= '0;
        end else begin
            pix_on    <= dot;
            pix_color <= dot ? color : '0;
        end
    end
endmodule

// File: rtl/osd_overlay.sv
module osd_overlay
    import osd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               pix_on,
    output logic [COLOR_W-1:0] pix_color
);
    osd_cfg_t          cfg;
    logic              frame_start, in_rows, nxt_hires;
    logic [POS_W-1:0]  nxt_vstart;
    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;

    osd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(frame_start), .active(cfg),
        .nxt_vstart(nxt_vstart), .nxt_hires(nxt_hires)
    );

    osd_timing u_timing (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .nxt_vstart(nxt_vstart), .nxt_hires(nxt_hires), .cur_vstart(cfg.vstart),
        .frame_start(frame_start), .hcnt(hcnt), .vcnt(vcnt), .in_rows(in_rows)
    );

    osd_render u_render (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .hcnt(hcnt), .vcnt(vcnt),
        .in_rows(in_rows), .pix_on(pix_on), .pix_color(pix_color)
    );

    // R10
    dark_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_on |-> $past(cfg.en));
endmodule

// File: tb/sim_osd_overlay.sv
module sim_osd_overlay;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b1, vsync = 1'b1, wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       pix_on;
    logic [2:0] pix_color;

    int nchk = 0, nfail = 0;
    bit done = 0;

    int sh_chr[160], ac_chr[160];
    int sh_rc[8], ac_rc[8];
    int sh_brow, ac_brow, sh_bcol, ac_bcol, sh_split, ac_split;
    int sh_hp, ac_hp, sh_vp, ac_vp;
    bit sh_en, ac_en, sh_hr, ac_hr;
    bit pre = 1, r3_zone = 0;
    int line_no = 0;

    always #2.5 clk = ~clk;

    osd_overlay u0 (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_on(pix_on), .pix_color(pix_color)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish (actual hung, expected done)");
            summary();
            $finish;
        end
    end

    // R1, R2: address map mirrored in the model
    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 8'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
        if (a < 160) sh_chr[a] = d & 127;
        else if (a < 168) sh_rc[a-160] = d & 7;
        else if (a == 168) sh_brow = d & 7;
        else if (a == 169) sh_bcol = d & 7;
        else if (a == 170) sh_split = d & 31;
        else if (a == 171) sh_hp = d & 255;
        else if (a == 172) sh_vp = d & 255;
        else if (a == 173) begin sh_en = d[0]; sh_hr = d[1]; end
    endtask

    task automatic commit_model();
        for (int i = 0; i < 160; i++) ac_chr[i] = sh_chr[i];
        for (int i = 0; i < 8; i++) ac_rc[i] = sh_rc[i];
        ac_brow = sh_brow; ac_bcol = sh_bcol; ac_split = sh_split;
        ac_hp = sh_hp; ac_vp = sh_vp; ac_en = sh_en; ac_hr = sh_hr;
    endtask

    function automatic void model(input int k, input int l, output bit on,
                                  output int col, output string tag);
        int cw, ch, x, y, c, r, gx, gy, code;
        on = 0; col = 0;
        if (pre) begin tag = "R11"; return; end
        if (!ac_en) begin tag = "R10"; return; end
        cw = ac_hr ? 12 : 6; ch = ac_hr ? 16 : 8;
        x = k - ac_hp; y = l - ac_vp;
        if (x < 0 || x >= 20*cw || y < 0 || y >= 8*ch) begin tag = "R5"; return; end
        c = x / cw; r = y / ch; gx = x % cw; gy = y % ch;
        code = ac_chr[r*20 + c];
        if (code == 0) begin tag = "R7"; return; end
        if (gx >= cw-1 || gy >= ch-1) begin tag = "R6"; return; end
        if (((code >> ((gx+gy) % 7)) & 1) == 0) begin tag = "R7"; return; end
        on = 1;
        if (r == ac_brow && c >= ac_split) begin col = ac_bcol; tag = "R9"; end
        else begin col = ac_rc[r]; tag = "R8"; end
    endfunction

    task automatic check_px(int k);
        bit eon; int ecol; string tag;
        model(k, line_no, eon, ecol, tag);
        if (r3_zone) tag = {"R3/", tag};
        nchk++;
        if (pix_on !== eon || pix_color !== 3'(ecol)) begin
            nfail++;
            $display("FAIL %s line %0d px %0d: actual on=%0b col=%0d expected on=%0b col=%0d",
                     tag, line_no, k, pix_on, pix_color, eon, ecol);
        end
    endtask

    // R4: pixel k is sampled k+2 falling clock edges after hsync is driven low
    task automatic run_line(int len);
        @(negedge clk);
        hsync = 0;
        for (int c = 1; c < len; c++) begin
            @(negedge clk);
            if (c >= 2) check_px(c - 2);
            if (c == 4) hsync = 1;
        end
    endtask

    task automatic scramble(int n);
        for (int i = 0; i < n; i++) wr($urandom_range(159), $urandom_range(127));
        for (int i = 0; i < 8; i++) wr(160 + i, $urandom_range(7));
        wr(170, $urandom_range(20));
        wr(171, $urandom_range(20));
    endtask

    task automatic frame(bit mid);
        int len, nl;
        len = sh_hp + 20 * (sh_hr ? 12 : 6) + 8;
        nl  = sh_vp + 8 * (sh_hr ? 16 : 8) + 2;
        @(negedge clk);
        vsync = 0;
        commit_model();
        pre = 0; line_no = 0; r3_zone = 0;
        repeat (3) @(negedge clk);
        vsync = 1;
        @(negedge clk);
        for (int l = 1; l < nl; l++) begin
            if (mid && l == nl / 2) begin scramble(24); r3_zone = 1; end
            line_no = l;
            run_line(len);
        end
        r3_zone = 0;
    endtask

    task automatic fill_random(int zero_pct);
        for (int i = 0; i < 160; i++)
            wr(i, ($urandom_range(99) < zero_pct) ? 0 : $urandom_range(1, 127));
        for (int i = 0; i < 8; i++) wr(160 + i, $urandom_range(7));
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 160; i++) begin sh_chr[i] = 0; ac_chr[i] = 0; end
        for (int i = 0; i < 8; i++) begin sh_rc[i] = 0; ac_rc[i] = 0; end
        {sh_brow, sh_bcol, sh_split, sh_hp, sh_vp} = '0;
        {sh_en, sh_hr} = '0;
        commit_model();
        repeat (4) @(negedge clk);
        // R11: reset state
        nchk++;
        if (pix_on !== 1'b0 || pix_color !== 3'd0) begin
            nfail++;
            $display("FAIL R11 reset: actual on=%0b col=%0d expected on=0 col=0", pix_on, pix_color);
        end
        rst_n = 1;
        // R11: settings written before any vsync stay dark
        wr(173, 1); wr(0, 127); wr(1, 127); wr(160, 5);
        for (int l = 0; l < 3; l++) begin line_no = l; run_line(140); end

        // Directed, coarse mode, zero offsets, bar split at column 0 (R9)
        for (int i = 0; i < 160; i++) wr(i, (i % 13 == 5) ? 0 : (i % 127) + 1);
        for (int i = 0; i < 8; i++) wr(160 + i, i);
        wr(168, 3); wr(169, 6); wr(170, 0); wr(171, 0); wr(172, 0); wr(173, 1);
        frame(0);

        // Random coarse frame with mid-frame shadow writes (R3)
        fill_random(25);
        wr(168, $urandom_range(7)); wr(169, $urandom_range(7));
        wr(170, $urandom_range(1, 19)); wr(171, $urandom_range(1, 20));
        wr(172, $urandom_range(1, 10));
        frame(1);
        // Shadow writes from the last frame now visible
        frame(0);

        // Fine mode, random split (R6, R9)
        fill_random(20);
        wr(168, $urandom_range(7)); wr(170, $urandom_range(1, 19));
        wr(171, $urandom_range(0, 20)); wr(172, $urandom_range(0, 10)); wr(173, 3);
        frame(0);

        // Fine mode, split beyond last column, largest horizontal offset used
        wr(170, 20); wr(171, 20); wr(172, 1);
        frame(0);

        // Display disabled (R10)
        wr(173, 0); wr(171, 3); wr(172, 2);
        frame(0);

        done = 1;
        summary();
        $finish;
    end
endmodule